// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the controller of a multicycle processor datapath. It holds the current step of the instruction in a state register. Every cycle it decides the next step from that state and from the opcode of the instruction register. It drives a fixed set of control strobes and selects as a pure function of the state (Moore outputs). A companion decoder turns the ALU operation class and the instruction's function field into a concrete ALU function code.

Two steps are shared by every instruction. The first step fetches the instruction and advances the PC by four. The second step reads both source registers and, ahead of need, computes a branch target into the ALU output register. After that the sequence splits by instruction class. Jumps and equality branches finish in three cycles. Register-register operations and stores finish in four. Loads finish in five. An opcode the controller does not support goes back to fetch straight after the shared decode step, and no write is asserted.

The interface is plain control pins with no handshake. The opcode and function inputs come from the instruction register. They must hold steady from the end of fetch until the instruction completes.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, the outputs show the fetch step. In that step mem_re=1, ir_we=1 and pc_we=1, with alu_b_sel=01, alu_a_sel=0, alu_op=00, mem_addr_alu=0 and pc_src=00. Every other strobe is 0.
- R2: Every instruction begins with fetch (as in R1). Decode follows in the next cycle. In decode, alu_a_sel=0, alu_b_sel=11 and alu_op=00, and every strobe is 0.
- R3: For opcode 000000 (register-register), the third cycle has alu_a_sel=1, alu_b_sel=00 and alu_op=10. The fourth cycle has rf_we=1, reg_dst_rd=1 and rf_from_mem=0. The fifth cycle is fetch.
- R4: For opcode 100011 (load), the third cycle has alu_a_sel=1, alu_b_sel=10 and alu_op=00. The fourth cycle has mem_re=1 and mem_addr_alu=1. The fifth cycle has rf_we=1, rf_from_mem=1 and reg_dst_rd=0. The sixth cycle is fetch.
- R5: For opcode 101011 (store), the third cycle is as in R4. The fourth cycle has mem_we=1 and mem_addr_alu=1. The fifth cycle is fetch.
- R6: For opcode 000100 (branch on equal), the third cycle has alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_we_zero=1 and pc_src=01. The fourth cycle is fetch.
- R7: For opcode 000010 (jump), the third cycle has pc_we=1 and pc_src=10. The fourth cycle is fetch.
- R8: Any other opcode makes the cycle after decode a fetch, and no write strobe is asserted in decode.
- R9: With alu_op encoded as 00 for add, 01 for subtract and 10 for use-funct, alu_fn gives add=0010 and subtract=0110. Under 10, funct 100000 gives 0010, 100010 gives 0110, 100100 gives 0000, 100101 gives 0001 and 101010 gives 0111, and any other funct gives 0010.
- R10: In every state, each control output not listed for that state is at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to fetch |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| reg_dst_rd | output | 1 | Write register is rd (1) or rt (0) |
| rf_we | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B: 00 register B, 01 constant 4, 10 sign-extended offset, 11 shifted offset |
| mem_re | output | 1 | Memory read |
| mem_we | output | 1 | Memory write |
| rf_from_mem | output | 1 | Register write data from MDR (1) or ALU output register (0) |
| mem_addr_alu | output | 1 | Memory address from ALU output register (1) or PC (0) |
| ir_we | output | 1 | Instruction register load |
| pc_we | output | 1 | Unconditional PC load |
| pc_we_zero | output | 1 | PC load when the ALU zero flag is set |
| alu_op | output | 2 | ALU operation class |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump address |
| alu_fn | output | 4 | Decoded ALU function code |

## Verification
A wrong state shows up at the ports in the same cycle it is entered, because every output decodes the state register directly. A wrong transition therefore gives a strobe vector that differs from the model within one clock: a missing write, a write in a shared step, or an instruction that ends a cycle early or late. The bench compares the full strobe vector and the ALU code every cycle against a per-instruction step model. It runs all five classes, unsupported opcodes, back-to-back sequences and every function code.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OP_W     = 6;
  localparam int FN_W     = 6;
  localparam int ALUFN_W  = 4;
  localparam int ST_W     = 4;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;

  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  typedef enum logic [ST_W-1:0] {
    S_FETCH, S_DECODE, S_ADDR, S_LDRD, S_LDWB, S_STWR,
    S_EXEC, S_RWB, S_BRANCH, S_JUMP
  } state_t;

  typedef struct packed {
    logic       reg_dst_rd;
    logic       rf_we;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       mem_re;
    logic       mem_we;
    logic       rf_from_mem;
    logic       mem_addr_alu;
    logic       ir_we;
    logic       pc_we;
    logic       pc_we_zero;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
  } ctrl_t;
endpackage

// File: rtl/mcc_next.sv
module mcc_next
  import mcc_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  state_t          cur,
  input  logic [OPW-1:0]  op,
  output state_t          nxt
);
  always_comb begin
    nxt = S_FETCH;
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        if (op == OP_LOAD || op == OP_STORE) nxt = S_ADDR;
        else if (op == OP_RTYPE)             nxt = S_EXEC;
        else if (op == OP_BEQ)               nxt = S_BRANCH;
        else if (op == OP_JUMP)              nxt = S_JUMP;
        else                                 nxt = S_FETCH;
      end
      S_ADDR:   nxt = (op == OP_LOAD) ? S_LDRD : S_STWR;
      S_LDRD:   nxt = S_LDWB;
      S_EXEC:   nxt = S_RWB;
      default:  nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_outdec.sv
module mcc_outdec
  import mcc_pkg::*;
(
  input  state_t cur,
  output ctrl_t  c
);
  always_comb begin
    c = '0;
    unique case (cur)
      S_FETCH: begin
        c.mem_re    = 1'b1;
        c.ir_we     = 1'b1;
        c.pc_we     = 1'b1;
        c.alu_b_sel = 2'b01;
        c.alu_op    = AOP_ADD;
      end
      S_DECODE: c.alu_b_sel = 2'b11;
      S_ADDR: begin
        c.alu_a_sel = 1'b1;
        c.alu_b_sel = 2'b10;
      end
      S_LDRD: begin
        c.mem_re       = 1'b1;
        c.mem_addr_alu = 1'b1;
      end
      S_LDWB: begin
        c.rf_we       = 1'b1;
        c.rf_from_mem = 1'b1;
      end
      S_STWR: begin
        c.mem_we       = 1'b1;
        c.mem_addr_alu = 1'b1;
      end
      S_EXEC: begin
        c.alu_a_sel = 1'b1;
        c.alu_op    = AOP_FUNCT;
      end
      S_RWB: begin
        c.rf_we      = 1'b1;
        c.reg_dst_rd = 1'b1;
      end
      S_BRANCH: begin
        c.alu_a_sel  = 1'b1;
        c.alu_op     = AOP_SUB;
        c.pc_we_zero = 1'b1;
        c.pc_src     = 2'b01;
      end
      S_JUMP: begin
        c.pc_we  = 1'b1;
        c.pc_src = 2'b10;
      end
      default: c = '0;
    endcase
  end
endmodule

// File: rtl/mcc_aluctl.sv
module mcc_aluctl
  import mcc_pkg::*;
#(
  parameter int FNW = FN_W,
  parameter int AFW = ALUFN_W
) (
  input  logic [1:0]     alu_op,
  input  logic [FNW-1:0] funct,
  output logic [AFW-1:0] alu_fn
);
  localparam logic [AFW-1:0] F_AND = AFW'(4'b0000);
  localparam logic [AFW-1:0] F_OR  = AFW'(4'b0001);
  localparam logic [AFW-1:0] F_ADD = AFW'(4'b0010);
  localparam logic [AFW-1:0] F_SUB = AFW'(4'b0110);
  localparam logic [AFW-1:0] F_SLT = AFW'(4'b0111);

  always_comb begin
    alu_fn = F_ADD;
    if (alu_op == AOP_SUB) alu_fn = F_SUB;
    else if (alu_op == AOP_FUNCT) begin
      case (funct)
        FNW'(6'b100010): alu_fn = F_SUB;
        FNW'(6'b100100): alu_fn = F_AND;
        FNW'(6'b100101): alu_fn = F_OR;
        FNW'(6'b101010): alu_fn = F_SLT;
        default:         alu_fn = F_ADD;
      endcase
    end
  end
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OP_W-1:0]    opcode,
  input  logic [FN_W-1:0]    funct,
  output logic               reg_dst_rd,
  output logic               rf_we,
  output logic               alu_a_sel,
  output logic [1:0]         alu_b_sel,
  output logic               mem_re,
  output logic               mem_we,
  output logic               rf_from_mem,
  output logic               mem_addr_alu,
  output logic               ir_we,
  output logic               pc_we,
  output logic               pc_we_zero,
  output logic [1:0]         alu_op,
  output logic [1:0]         pc_src,
  output logic [ALUFN_W-1:0] alu_fn
);
  state_t state_q, state_d;
  ctrl_t  ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_FETCH;
    else        state_q <= state_d;
  end

  mcc_next #(.OPW(OP_W)) u_next (.cur(state_q), .op(opcode), .nxt(state_d));
  mcc_outdec u_dec (.cur(state_q), .c(ctl));
  mcc_aluctl #(.FNW(FN_W), .AFW(ALUFN_W)) u_alu (
    .alu_op(ctl.alu_op), .funct(funct), .alu_fn(alu_fn));

  assign reg_dst_rd   = ctl.reg_dst_rd;
  assign rf_we        = ctl.rf_we;
  assign alu_a_sel    = ctl.alu_a_sel;
  assign alu_b_sel    = ctl.alu_b_sel;
  assign mem_re       = ctl.mem_re;
  assign mem_we       = ctl.mem_we;
  assign rf_from_mem  = ctl.rf_from_mem;
  assign mem_addr_alu = ctl.mem_addr_alu;
  assign ir_we        = ctl.ir_we;
  assign pc_we        = ctl.pc_we;
  assign pc_we_zero   = ctl.pc_we_zero;
  assign alu_op       = ctl.alu_op;
  assign pc_src       = ctl.pc_src;

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> (state_q == S_DECODE && !rf_we && !mem_we && !pc_we)); // R2
  AST_RWB_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == AOP_FUNCT) |=> (rf_we && reg_dst_rd)); // R3
  AST_LOAD_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && mem_addr_alu) |=> (rf_we && rf_from_mem)); // R4
  AST_STORE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ir_we); // R5
  AST_BRANCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we_zero |=> ir_we); // R6
  AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && (rf_we || mem_re || pc_we))); // R10
  AST_ALUOP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    alu_op != 2'b11); // R9
endmodule

// File: tb/sim_mc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_mc_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic [5:0] opcode, funct;
  logic reg_dst_rd, rf_we, alu_a_sel, mem_re, mem_we, rf_from_mem;
  logic mem_addr_alu, ir_we, pc_we, pc_we_zero;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic [3:0] alu_fn;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mc_seq_ctrl u0 (.*);

  function automatic logic [16:0] ref_vec(logic [5:0] op, int step);
    logic rd = 0, rw = 0, sa = 0, mr = 0, mw = 0, m2r = 0, iod = 0;
    logic irw = 0, pcw = 0, pcc = 0;
    logic [1:0] sb = 0, ao = 0, ps = 0;
    if (step == 0) begin mr = 1; irw = 1; pcw = 1; sb = 2'b01; end
    else if (step == 1) sb = 2'b11;
    else case (op)
      6'h00: if (step == 2) begin sa = 1; ao = 2'b10; end
             else begin rd = 1; rw = 1; end
      6'h23: if (step == 2) begin sa = 1; sb = 2'b10; end
             else if (step == 3) begin mr = 1; iod = 1; end
             else begin rw = 1; m2r = 1; end
      6'h2b: if (step == 2) begin sa = 1; sb = 2'b10; end
             else begin mw = 1; iod = 1; end
      6'h04: begin sa = 1; ao = 2'b01; pcc = 1; ps = 2'b01; end
      6'h02: begin pcw = 1; ps = 2'b10; end
      default: ;
    endcase
    return {rd, rw, sa, sb, mr, mw, m2r, iod, irw, pcw, pcc, ao, ps};
  endfunction

  function automatic int ilen(logic [5:0] op);
    case (op)
      6'h00: return 4; 6'h23: return 5; 6'h2b: return 4;
      6'h04: return 3; 6'h02: return 3; default: return 2;
    endcase
  endfunction

  function automatic logic [3:0] ref_alu(logic [1:0] ao, logic [5:0] fn);
    if (ao == 2'b01) return 4'b0110;
    if (ao != 2'b10) return 4'b0010;
    case (fn)
      6'b100010: return 4'b0110;
      6'b100100: return 4'b0000;
      6'b100101: return 4'b0001;
      6'b101010: return 4'b0111;
      default:   return 4'b0010;
    endcase
  endfunction

  function automatic string tag(logic [5:0] op, int step);
    if (ilen(op) == 2) return "R8";
    if (step < 2) return "R2";
    case (op)
      6'h00: return "R3"; 6'h23: return "R4"; 6'h2b: return "R5";
      6'h04: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic compare(string t, logic [5:0] op, int step);
    logic [16:0] act, exp;
    logic [3:0] ea;
    act = {reg_dst_rd, rf_we, alu_a_sel, alu_b_sel, mem_re, mem_we,
           rf_from_mem, mem_addr_alu, ir_we, pc_we, pc_we_zero, alu_op, pc_src};
    exp = ref_vec(op, step);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/R10 op=%h step=%0d ctrl act=%b exp=%b", t, op, step, act, exp);
    end
    ea = ref_alu(exp[3:2], funct);
    checks++;
    if (alu_fn !== ea) begin
      errors++;
      $display("FAIL R9 op=%h fn=%b alu_fn act=%b exp=%b", op, funct, alu_fn, ea);
    end
  endtask

  localparam int N = 17;
  logic [5:0] ops [N] = '{6'h00, 6'h23, 6'h2b, 6'h04, 6'h02, 6'h3f, 6'h00, 6'h00,
                         6'h00, 6'h00, 6'h00, 6'h08, 6'h23, 6'h04, 6'h2b, 6'h02, 6'h00};
  logic [5:0] fns [N] = '{6'b100000, 6'b100010, 6'b101010, 6'b100100, 6'b000000,
                         6'b100010, 6'b100010, 6'b100100, 6'b100101, 6'b101010,
                         6'b111111, 6'b100101, 6'b000000, 6'b100000, 6'b100101,
                         6'b101010, 6'b000001};

  initial begin
    rst_n = 1'b0; opcode = 6'h23; funct = 6'b100010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1", 6'h23, 0);
    rst_n = 1'b1;
    compare("R1", 6'h23, 0);
    for (int i = 0; i < N; i++) begin
      opcode = ops[i];
      funct  = fns[i];
      for (int s = 0; s < ilen(ops[i]); s++) begin
        if (!(i == 0 && s == 0)) compare(tag(ops[i], s), ops[i], s);
        @(posedge clk);
        @(negedge clk);
      end
    end
    compare("R2", 6'h00, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule